// File: doc/BRIEF.md
# Dual-Rail Fault Monitor

This block supervises a controller that reports its health on two wires carrying complementary levels. Both wires pass through a two-flop synchronizer. Each synchronized pair is then decoded as healthy, faulted or invalid. A code takes effect only after it has stayed unchanged for a programmable number of clock samples, so short glitches are filtered out.

Once a fault or invalid code has been qualified, the block reacts in one of two ways, chosen by a configuration input. It can drive a reset request low for a fixed number of cycles. It can instead pull a fail-safe output low and hold it there until software clears it while the pair reads healthy.

An enable input masks the lines while the supervised controller is in reset or self-test, because its outputs float during that phase. A small read port returns a status word.

Top module: `dfm_monitor`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `rst_req_n` and `fs_n` are 1 and `reg_rdata` is 0.
- R2: The pair is `{fault_pair_i[1], fault_pair_i[0]}`. 01 means healthy, 10 means fault, and 00 or 11 means invalid. A qualified invalid code counts as a fault and also sets the invalid status bit.
- R3: Let S be `stable_cycles`. A pair presented before clock edge t0 and held is accepted at edge t0+1+S, and any reaction output changes at edge t0+2+S. A pair held for fewer than S synchronized samples is never accepted.
- R4: A `stable_cycles` value of 0 is treated as 1.
- R5: While `mon_en` is 0, the lines are ignored and the accepted code is forced to healthy. Qualification restarts from zero when `mon_en` returns to 1. If `mon_en` is 0 in the cycle in which qualification would complete, no fault is taken.
- R6: With `cfg_latch_mode` = 0, a newly accepted fault drives `rst_req_n` low for exactly 16 cycles, and `fs_n` stays 1.
- R7: With `cfg_latch_mode` = 1, a newly accepted fault drives `fs_n` low and leaves `rst_req_n` at 1.
- R8: Once low, `fs_n` returns to 1 only on a `sw_clear` cycle in which the accepted code is healthy. A clear given while the accepted code is still fault or invalid has no effect.
- R9: A `reg_rd` cycle with `reg_addr` = 0 loads `reg_rdata` on the next edge with the status word. The status bits are: bit0 fault active, bit1 invalid code, bit2 fail-safe latched, bit3 reset pulse active, bit4 `mon_en`, and the upper bits 0. A read of any other address loads 0. Without `reg_rd`, `reg_rdata` holds its value.
- R10: A change from one fault-class code to another (fault to invalid, or invalid to fault) does not start a new reaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | 1 = monitor the lines, 0 = mask them |
| fault_pair_i | input | 2 | Complementary fault lines from the supervised controller |
| stable_cycles | input | CW | Number of samples a code must stay unchanged before it is accepted |
| cfg_latch_mode | input | 1 | 0 = pulse the reset request, 1 = latch the fail-safe output |
| sw_clear | input | 1 | Software request to release the fail-safe output |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | AW | Read address |
| reg_rdata | output | DW | Registered read data |
| rst_req_n | output | 1 | Active-low reset request pulse |
| fs_n | output | 1 | Active-low latched fail-safe output |

## Verification
Two pairs of functions can meet in the same cycle.

The first pair is masking and qualification. The bench sets a fault code and drops `mon_en` exactly on the edge at which the S-th matching sample would be accepted. It then expects no reaction, and it expects the count to start over once `mon_en` comes back.

The second pair is software clear and a still-active fault. The bench asserts `sw_clear` after the lines have returned to healthy but before the healthy code has been qualified. It expects `fs_n` to stay low.

In both cases a behavioural reference model decides the outcome, and the bench compares it with the outputs on every clock.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
  typedef enum logic [1:0] {
    CODE_OK  = 2'd0,
    CODE_FLT = 2'd1,
    CODE_BAD = 2'd2
  } pair_code_t;

  localparam logic [1:0] PAIR_IDLE = 2'b01;

  function automatic pair_code_t decode_pair(input logic [1:0] p);
    case (p)
      2'b01:   return CODE_OK;
      2'b10:   return CODE_FLT;
      default: return CODE_BAD;
    endcase
  endfunction
endpackage

// File: rtl/dfm_sync.sv
module dfm_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/dfm_qualify.sv
module dfm_qualify
  import dfm_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [1:0]    pair_i,
  input  logic [CW-1:0] stable_i,
  output pair_code_t    code_o
);
  localparam logic [CW-1:0] RUN_MAX = '1;
  localparam logic [CW-1:0] RUN_ONE = CW'(1);

  logic [CW-1:0] run_q, run_n, thr;
  pair_code_t    last_q, dec;

  always_comb begin
    dec = decode_pair(pair_i);
    thr = (stable_i == '0) ? RUN_ONE : stable_i;
    if (run_q != '0 && dec == last_q)
      run_n = (run_q == RUN_MAX) ? run_q : run_q + RUN_ONE;
    else
      run_n = RUN_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      run_q  <= '0;
      last_q <= CODE_OK;
      code_o <= CODE_OK;
    end else begin
      run_q  <= run_n;
      last_q <= dec;
      if (run_n >= thr) code_o <= dec;
    end
  end

  AST_MASK_FORCES_OK: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> code_o == CODE_OK); // R5
  AST_ACCEPT_MATCHES_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    ($past(en_i) && code_o != $past(code_o)) |-> code_o == decode_pair($past(pair_i))); // R3
endmodule

// File: rtl/dfm_react.sv
module dfm_react
  import dfm_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  pair_code_t code_i,
  input  logic       latch_mode_i,
  input  logic       clear_i,
  output logic       rst_req_n_o,
  output logic       fs_n_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] cnt_q;
  logic          flt_prev, flt_now, rise;

  assign flt_now = (code_i != CODE_OK);
  assign rise    = flt_now && !flt_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_prev    <= 1'b0;
      cnt_q       <= '0;
      rst_req_n_o <= 1'b1;
      fs_n_o      <= 1'b1;
    end else begin
      flt_prev <= flt_now;
      if (rise && !latch_mode_i) begin
        cnt_q       <= PW'(PULSE_LEN - 1);
        rst_req_n_o <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - PW'(1);
      end else begin
        rst_req_n_o <= 1'b1;
      end
      if (rise && latch_mode_i)
        fs_n_o <= 1'b0;
      else if (clear_i && code_i == CODE_OK)
        fs_n_o <= 1'b1;
    end
  end

  AST_REACT_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    rise |=> (!rst_req_n_o || !fs_n_o)); // R6
  AST_PULSE_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req_n_o) |-> $past(rise && !latch_mode_i)); // R6
  AST_FS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fs_n_o && !(clear_i && code_i == CODE_OK)) |=> !fs_n_o); // R8
  AST_FS_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    $fell(fs_n_o) |-> $past(latch_mode_i)); // R7
endmodule

// File: rtl/dfm_monitor.sv
module dfm_monitor
  import dfm_pkg::*;
#(
  parameter int CW        = 4,
  parameter int PULSE_LEN = 16,
  parameter int AW        = 2,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mon_en,
  input  logic [1:0]    fault_pair_i,
  input  logic [CW-1:0] stable_cycles,
  input  logic          cfg_latch_mode,
  input  logic          sw_clear,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_rdata,
  output logic          rst_req_n,
  output logic          fs_n
);
  logic [1:0]    pair_s;
  pair_code_t    code;
  logic [DW-1:0] status;

  dfm_sync #(.W(2), .RST_VAL(PAIR_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i(fault_pair_i), .q_o(pair_s)
  );

  dfm_qualify #(.CW(CW)) u_qual (
    .clk(clk), .rst(rst), .en_i(mon_en), .pair_i(pair_s),
    .stable_i(stable_cycles), .code_o(code)
  );

  dfm_react #(.PULSE_LEN(PULSE_LEN)) u_react (
    .clk(clk), .rst(rst), .code_i(code), .latch_mode_i(cfg_latch_mode),
    .clear_i(sw_clear), .rst_req_n_o(rst_req_n), .fs_n_o(fs_n)
  );

  always_comb begin
    status    = '0;
    status[0] = (code != CODE_OK);
    status[1] = (code == CODE_BAD);
    status[2] = ~fs_n;
    status[3] = ~rst_req_n;
    status[4] = mon_en;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= (reg_addr == '0) ? status : '0;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr != '0) |=> reg_rdata == '0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R9
endmodule

// File: tb/sim_dfm_monitor.sv
`timescale 1ns/1ps
module sim_dfm_monitor;
  logic       clk = 0;
  logic       rst = 1;
  logic       mon_en = 0;
  logic [1:0] fault_pair_i = 2'b01;
  logic [3:0] stable_cycles = 4'd4;
  logic       cfg_latch_mode = 0;
  logic       sw_clear = 0;
  logic       reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_rdata;
  logic       rst_req_n, fs_n;

  always #5 clk = ~clk;

  dfm_monitor u0 (
    .clk(clk), .rst(rst), .mon_en(mon_en), .fault_pair_i(fault_pair_i),
    .stable_cycles(stable_cycles), .cfg_latch_mode(cfg_latch_mode),
    .sw_clear(sw_clear), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .rst_req_n(rst_req_n), .fs_n(fs_n)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_p1, m_p2, m_acc, m_last, m_run, m_rleft, m_thr;
  bit m_fprev, m_fs;
  logic [7:0] m_rd;

  function automatic int code_of(int p);
    if (p == 1) return 0;
    if (p == 2) return 1;
    return 2;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_p1 = 1; m_p2 = 1; m_acc = 0; m_last = 0; m_run = 0;
      m_rleft = 0; m_fprev = 0; m_fs = 0; m_rd = 0;
    end else begin
      int o_acc, o_rl, smp, d;
      bit o_fs, rise;
      o_acc = m_acc; o_rl = m_rleft; o_fs = m_fs;
      if (reg_rd)
        m_rd = (reg_addr == 0) ? {3'b000, mon_en, o_rl != 0, o_fs, o_acc == 2, o_acc != 0} : 8'h00;
      rise = (o_acc != 0) && !m_fprev;
      m_fprev = (o_acc != 0);
      if (rise && !cfg_latch_mode) m_rleft = 16;
      else if (m_rleft > 0) m_rleft--;
      if (rise && cfg_latch_mode) m_fs = 1;
      else if (sw_clear && o_acc == 0) m_fs = 0;
      smp = m_p2; m_p2 = m_p1; m_p1 = int'(fault_pair_i);
      d = code_of(smp);
      if (!mon_en) begin
        m_run = 0; m_last = 0; m_acc = 0;
      end else begin
        if (m_run > 0 && d == m_last) m_run = (m_run < 15) ? m_run + 1 : 15;
        else m_run = 1;
        m_last = d;
        m_thr = (stable_cycles == 0) ? 1 : int'(stable_cycles);
        if (m_run >= m_thr) m_acc = d;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // pulse observation
  int low_run = 0, last_pulse_len = 0, n_pulses = 0;
  logic prev_rr = 1;

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "rst_req_n", rst_req_n, (m_rleft == 0));
      chk(cur_req, "fs_n", fs_n, !m_fs);
      chk(cur_req, "reg_rdata", reg_rdata, m_rd);
      if (!rst_req_n) low_run++;
      if (prev_rr && !rst_req_n) n_pulses++;
      if (!prev_rr && rst_req_n) begin last_pulse_len = low_run; low_run = 0; end
      prev_rr = rst_req_n;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pair(input logic [1:0] p, input int hold);
    @(negedge clk); fault_pair_i = p;
    idle(hold);
  endtask

  task automatic read_reg(input logic [1:0] a);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse_clear;
    @(negedge clk); sw_clear = 1;
    @(negedge clk); sw_clear = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    int np;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rst_req_n in reset", rst_req_n, 1);
    chk("R1", "fs_n in reset", fs_n, 1);
    chk("R1", "reg_rdata in reset", reg_rdata, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "rst_req_n after reset", rst_req_n, 1);
    chk("R1", "fs_n after reset", fs_n, 1);
    mon_en = 1;
    idle(10);

    // R3: glitch shorter than S is filtered
    cur_req = "R3";
    set_pair(2'b10, 2);
    set_pair(2'b01, 30);
    chk("R3", "pulses after short glitch", n_pulses, 0);

    // R6: reset-pulse reaction
    cur_req = "R6";
    set_pair(2'b10, 7);
    set_pair(2'b01, 40);
    chk("R6", "pulse count", n_pulses, 1);
    chk("R6", "pulse length", last_pulse_len, 16);
    chk("R6", "fs_n untouched", fs_n, 1);

    // R2: invalid code and status word
    cur_req = "R2";
    set_pair(2'b00, 10);
    read_reg(2'd0);
    chk("R2", "status fault/invalid bits", reg_rdata[1:0], 2'b11);
    chk("R2", "invalid code pulse", n_pulses, 2);
    // R10: fault-class to fault-class does not retrigger
    cur_req = "R10";
    np = n_pulses;
    set_pair(2'b10, 30);
    set_pair(2'b11, 30);
    chk("R10", "no new pulse", n_pulses, np);
    set_pair(2'b01, 40);

    // R7: latched fail-safe
    cur_req = "R7";
    cfg_latch_mode = 1;
    np = n_pulses;
    set_pair(2'b10, 10);
    chk("R7", "fs_n latched", fs_n, 0);
    chk("R7", "no reset pulse", n_pulses, np);
    // R8: clear ignored while fault accepted
    cur_req = "R8";
    pulse_clear();
    idle(2);
    chk("R8", "clear during fault", fs_n, 0);
    fault_pair_i = 2'b01;
    idle(2);
    pulse_clear(); // healthy on lines, not yet accepted
    idle(2);
    chk("R8", "clear before healthy qualified", fs_n, 0);
    idle(10);
    pulse_clear();
    idle(1);
    chk("R8", "clear while healthy", fs_n, 1);

    // R5: masking and coincidence with qualification completion
    cur_req = "R5";
    cfg_latch_mode = 0;
    np = n_pulses;
    @(negedge clk); mon_en = 0; fault_pair_i = 2'b10;
    idle(20);
    chk("R5", "masked fault ignored", n_pulses, np);
    read_reg(2'd0);
    chk("R5", "status while masked", reg_rdata, 0);
    set_pair(2'b01, 10);
    @(negedge clk); mon_en = 1;
    idle(10);
    @(negedge clk); fault_pair_i = 2'b10;
    idle(5);
    mon_en = 0;
    idle(3);
    chk("R5", "mask wins at completion", n_pulses, np);
    mon_en = 1;
    idle(3);
    chk("R5", "restart not yet complete", n_pulses, np);
    idle(30);
    chk("R5", "fault after restart", n_pulses, np + 1);
    set_pair(2'b01, 40);

    // R4: zero threshold treated as one
    cur_req = "R4";
    stable_cycles = 4'd0;
    np = n_pulses;
    set_pair(2'b10, 0);
    set_pair(2'b01, 40);
    chk("R4", "single-sample fault accepted", n_pulses, np + 1);
    stable_cycles = 4'd4;

    // R9: unmapped reads and hold
    cur_req = "R9";
    read_reg(2'd0);
    chk("R9", "status enable bit", reg_rdata, 8'h10);
    read_reg(2'd1);
    chk("R9", "addr 1 reads zero", reg_rdata, 0);
    read_reg(2'd0);
    read_reg(2'd3);
    idle(5);
    chk("R9", "rdata holds", reg_rdata, 0);

    idle(5);
    finish_run();
  end
endmodule